// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the feedback divider (M), output divider (N) and test-select (T) settings of a clock synthesizer. It accepts them in one of two ways. In parallel mode a 9-bit M word and a 2-bit N word come in on pins. In serial mode a 14-bit word comes in through a shift register that is clocked by a serial clock, fed by a serial data line and committed by a load strobe. The M, N and T outputs are registered. A status flag shows whether the active M value lies inside the range where the loop can lock. A one-cycle strobe marks every change of the settings.

Every input is asynchronous to the system clock. Each one passes through a synchronizer of configurable depth. Edges of the serial clock are found in the system clock domain, so that clock must run at least four times faster than the serial clock. The parallel-load input is active low and has priority. While it is low, the pins drive the outputs directly and the serial side is frozen. While it is high, the serial strobe decides. When the strobe is high, the outputs follow the shift register on every cycle. This covers both a load on the rising edge and a pass-through while the strobe stays high. When the strobe is low, the outputs hold their values.

Top module: `synth_cfg_if`

## Requirements
- R1: After reset, m_cfg is all ones (511), n_cfg is all ones (3), t_cfg is 000, m_ok is 0 and ser_q is 0.
- R2: While pload_n is low, m_cfg and n_cfg follow m_pin and n_pin, and t_cfg is 000. This holds even if a serial load set T earlier.
- R3: When pload_n rises, the pin values of that moment are kept. Later changes on m_pin or n_pin have no effect until pload_n goes low again.
- R4: While pload_n is high, each rising edge of sclk shifts sdata into bit 0 of the 14-bit shift register and moves the other bits up by one. After 14 shifts, the first bit sent sits in bit 13. ser_q always shows bit 13.
- R5: A rising edge on sload while pload_n is high copies the shift register to the outputs. Bits 13:11 go to t_cfg, bits 10:9 to n_cfg and bits 8:0 to m_cfg.
- R6: While pload_n is high and sload is low, m_cfg, n_cfg and t_cfg hold their values through any serial shifts and any pin changes. This includes the values latched when sload falls.
- R7: While pload_n and sload are both high, each serial shift appears on m_cfg, n_cfg and t_cfg with the same bit mapping as R5.
- R8: m_ok is 1 exactly when m_cfg lies in the range 125 to 350, both ends included.
- R9: cfg_upd is high for exactly one cycle each time any of m_cfg, n_cfg or t_cfg changes, and is low otherwise.
- R10: While pload_n is low, sclk edges do not shift the register, so ser_q keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pload_n | input | 1 | Parallel-load control, active low; idle level high |
| m_pin | input | 9 | Parallel M value; idle level all ones |
| n_pin | input | 2 | Parallel N value; idle level all ones |
| sclk | input | 1 | Serial shift clock; idle level low |
| sdata | input | 1 | Serial data; idle level low |
| sload | input | 1 | Serial load strobe; idle level low |
| m_cfg | output | 9 | Active M divider value |
| n_cfg | output | 2 | Active N divider code |
| t_cfg | output | 3 | Active test-select code |
| ser_q | output | 1 | Top bit of the shift register |
| m_ok | output | 1 | Active M is inside the lock range |
| cfg_upd | output | 1 | One-cycle pulse on any settings change |

## Verification
The bound checker watches the synchronized control levels on every cycle. It checks that the outputs hold when the strobe is low, that they copy the shift register when the strobe is high, that they follow the pins with T cleared while the parallel-load input is low, and that the shift register stays frozen in that mode. It also checks on every cycle that the range flag matches the active M value and that the update pulse matches a change of the settings. The bench scenarios cover the parts a single-cycle property cannot see. These are the end-to-end serial bit order (the first bit sent ends up as T2), the reset values, the latch when the parallel-load input is released followed by ignored pin changes, the range boundaries 124, 125, 350 and 351, and the exact number of update pulses across each step.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W    = 9;
  localparam int N_W    = 2;
  localparam int T_W    = 3;
  localparam int WORD_W = T_W + N_W + M_W;

  // Serial word layout: T in the top bits, then N, then M in the low bits.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sck,
  input  logic         din,
  output logic [W-1:0] sr_q,
  output logic         ser_q
);
  logic sck_d;
  logic shift_now;

  assign shift_now = en && sck && !sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      sr_q  <= '0;
    end else begin
      sck_d <= sck;
      if (shift_now) sr_q <= {sr_q[W-2:0], din};
    end
  end

  assign ser_q = sr_q[W-1];
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int M_LO = 125,
  parameter int M_HI = 350
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pl_s,
  input  logic           sl_s,
  input  logic [M_W-1:0] m_s,
  input  logic [N_W-1:0] n_s,
  input  cfg_t           sr,
  output cfg_t           cur,
  output logic           m_ok,
  output logic           upd
);
  localparam logic [M_W-1:0] LO = M_W'(M_LO);
  localparam logic [M_W-1:0] HI = M_W'(M_HI);

  cfg_t nxt;

  always_comb begin
    nxt = cur;
    if (!pl_s) begin
      nxt.t = '0;
      nxt.n = n_s;
      nxt.m = m_s;
    end else if (sl_s) begin
      nxt = sr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur.t <= '0;
      cur.n <= '1;
      cur.m <= '1;
      m_ok  <= 1'b0;
      upd   <= 1'b0;
    end else begin
      cur  <= nxt;
      m_ok <= (nxt.m >= LO) && (nxt.m <= HI);
      upd  <= (nxt != cur);
    end
  end
endmodule

// File: rtl/synth_cfg_if.sv
module synth_cfg_if
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_LO        = 125,
  parameter int M_HI        = 350
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pload_n,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           sclk,
  input  logic           sdata,
  input  logic           sload,
  output logic [M_W-1:0] m_cfg,
  output logic [N_W-1:0] n_cfg,
  output logic [T_W-1:0] t_cfg,
  output logic           ser_q,
  output logic           m_ok,
  output logic           cfg_upd
);
  localparam int PW = M_W + N_W;

  logic              pl_s, sl_s, sc_s, sd_s;
  logic [PW-1:0]     pins_s;
  logic [M_W-1:0]    m_s;
  logic [N_W-1:0]    n_s;
  logic [WORD_W-1:0] sr_q;
  cfg_t              cur;

  cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pl
    (.clk(clk), .rst(rst), .d(pload_n), .q(pl_s));
  cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sl
    (.clk(clk), .rst(rst), .d(sload), .q(sl_s));
  cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sc
    (.clk(clk), .rst(rst), .d(sclk), .q(sc_s));
  cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sd
    (.clk(clk), .rst(rst), .d(sdata), .q(sd_s));
  cfg_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL({PW{1'b1}})) u_pins
    (.clk(clk), .rst(rst), .d({n_pin, m_pin}), .q(pins_s));

  assign m_s = pins_s[M_W-1:0];
  assign n_s = pins_s[PW-1:M_W];

  cfg_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .en(pl_s), .sck(sc_s), .din(sd_s),
    .sr_q(sr_q), .ser_q(ser_q)
  );

  cfg_regs #(.M_LO(M_LO), .M_HI(M_HI)) u_regs (
    .clk(clk), .rst(rst), .pl_s(pl_s), .sl_s(sl_s),
    .m_s(m_s), .n_s(n_s), .sr(cfg_t'(sr_q)),
    .cur(cur), .m_ok(m_ok), .upd(cfg_upd)
  );

  assign m_cfg = cur.m;
  assign n_cfg = cur.n;
  assign t_cfg = cur.t;
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
  import synth_cfg_pkg::*;
#(
  parameter int M_LO = 125,
  parameter int M_HI = 350
) (
  input logic              clk,
  input logic              rst,
  input logic              pl_s,
  input logic              sl_s,
  input logic [M_W-1:0]    m_s,
  input logic [N_W-1:0]    n_s,
  input logic [WORD_W-1:0] sr_q,
  input logic [M_W-1:0]    m_cfg,
  input logic [N_W-1:0]    n_cfg,
  input logic [T_W-1:0]    t_cfg,
  input logic              m_ok,
  input logic              cfg_upd
);
  logic [WORD_W-1:0] cfg_w;
  assign cfg_w = {t_cfg, n_cfg, m_cfg};

  a_r2_par_follow: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> (t_cfg == '0 && m_cfg == $past(m_s) && n_cfg == $past(n_s)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (pl_s && !sl_s) |=> $stable(cfg_w));

  a_r7_track: assert property (@(posedge clk) disable iff (rst)
    (pl_s && sl_s) |=> (cfg_w == $past(sr_q)));

  a_r8_range: assert property (@(posedge clk) disable iff (rst)
    m_ok == ((int'(m_cfg) >= M_LO) && (int'(m_cfg) <= M_HI)));

  a_r9_upd_on_change: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_w) |-> cfg_upd);

  a_r9_upd_only_on_change: assert property (@(posedge clk) disable iff (rst)
    cfg_upd |-> !$stable(cfg_w));

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> $stable(sr_q));
endmodule

bind synth_cfg_if synth_cfg_chk #(.M_LO(M_LO), .M_HI(M_HI)) u_chk (
  .clk(clk), .rst(rst), .pl_s(pl_s), .sl_s(sl_s), .m_s(m_s), .n_s(n_s),
  .sr_q(sr_q), .m_cfg(m_cfg), .n_cfg(n_cfg), .t_cfg(t_cfg),
  .m_ok(m_ok), .cfg_upd(cfg_upd)
);

// File: tb/synth_cfg_if_bench.sv
module synth_cfg_if_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       pload_n = 1'b1;
  logic [8:0] m_pin   = 9'h1FF;
  logic [1:0] n_pin   = 2'b11;
  logic       sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [8:0] m_cfg;
  logic [1:0] n_cfg;
  logic [2:0] t_cfg;
  logic       ser_q, m_ok, cfg_upd;

  synth_cfg_if u_synth_cfg_if (
    .clk(clk), .rst(rst), .pload_n(pload_n), .m_pin(m_pin), .n_pin(n_pin),
    .sclk(sclk), .sdata(sdata), .sload(sload),
    .m_cfg(m_cfg), .n_cfg(n_cfg), .t_cfg(t_cfg),
    .ser_q(ser_q), .m_ok(m_ok), .cfg_upd(cfg_upd)
  );

  typedef struct {
    logic [8:0] m; logic [1:0] n; logic [2:0] t;
    logic v; logic so; int updd; string req;
  } exp_t;

  exp_t  q[$];
  event  chk_ev;
  int    checks = 0, errors = 0, upd_cnt = 0, last_cnt = 0;
  logic [13:0] e_sr = '0;
  logic [8:0]  em = 9'h1FF, pm = 9'h1FF;
  logic [1:0]  en = 2'b11,  pn = 2'b11;
  logic [2:0]  et = 3'b000, pt = 3'b000;

  always @(posedge clk) if (!rst && cfg_upd) upd_cnt++;

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      cmp(it.req, "m_cfg", int'(m_cfg), int'(it.m));
      cmp(it.req, "n_cfg", int'(n_cfg), int'(it.n));
      cmp(it.req, "t_cfg", int'(t_cfg), int'(it.t));
      cmp(it.req, "m_ok",  int'(m_ok),  int'(it.v));
      cmp(it.req, "ser_q", int'(ser_q), int'(it.so));
      if (it.updd >= 0) cmp(it.req, "upd pulses", upd_cnt - last_cnt, it.updd);
      last_cnt = upd_cnt;
    end
  end

  task automatic wait_cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  // requirement model: parallel low wins (R2), strobe high copies word (R5/R7)
  task automatic apply_model();
    if (!pload_n) begin et = 3'b000; en = n_pin; em = m_pin; end
    else if (sload) {et, en, em} = e_sr;
  endtask

  task automatic expect_now(string req);
    exp_t it;
    it.m = em; it.n = en; it.t = et;
    it.v = (em >= 9'd125) && (em <= 9'd350);
    it.so = e_sr[13];
    it.updd = ({em, en, et} != {pm, pn, pt}) ? 1 : 0;
    it.req = req;
    pm = em; pn = en; pt = et;
    q.push_back(it);
    ->chk_ev;
    @(negedge clk);
  endtask

  task automatic set_pins(logic [8:0] m, logic [1:0] n);
    m_pin = m; n_pin = n; wait_cyc(8); apply_model();
  endtask

  task automatic set_pl(logic v);
    pload_n = v; wait_cyc(8); apply_model();
  endtask

  task automatic set_sl(logic v);
    sload = v; wait_cyc(8); apply_model();
  endtask

  task automatic send_bit(logic b);
    sdata = b; wait_cyc(4);
    sclk = 1'b1; wait_cyc(4);
    sclk = 1'b0; wait_cyc(4);
    if (pload_n) e_sr = {e_sr[12:0], b};
    apply_model();
  endtask

  task automatic send_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5); rst = 1'b0; wait_cyc(4);
    expect_now("R1 reset");

    // parallel transparent path and range edges
    set_pins(9'd200, 2'b01); set_pl(1'b0);     expect_now("R2 par follow");
    set_pins(9'd100, 2'b10);                   expect_now("R2 R8 below range");
    set_pins(9'd124, 2'b10);                   expect_now("R8 m=124");
    set_pins(9'd125, 2'b10);                   expect_now("R8 m=125");
    set_pins(9'd350, 2'b00);                   expect_now("R8 m=350");
    set_pins(9'd351, 2'b00);                   expect_now("R8 m=351");
    set_pins(9'd250, 2'b00);                   expect_now("R2 set 250");

    // latch on release
    set_pl(1'b1);                              expect_now("R3 release");
    set_pins(9'd300, 2'b11);                   expect_now("R3 pins ignored");

    // serial shift with strobe low: outputs hold (R6), bit order (R4)
    send_word({3'b101, 2'b10, 9'd333});        expect_now("R4 R6 shift hold");
    set_sl(1'b1);                              expect_now("R5 load rise");
    set_sl(1'b0);                              expect_now("R6 latch fall");
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
                                               expect_now("R6 hold after fall");

    // pass-through while strobe held high
    set_sl(1'b1);                              expect_now("R7 strobe high");
    send_bit(1'b0);                            expect_now("R7 pass bit0");
    send_bit(1'b1);                            expect_now("R7 pass bit1");
    send_bit(1'b1);                            expect_now("R7 pass bit2");
    send_bit(1'b0);                            expect_now("R7 pass bit3");
    set_sl(1'b0);

    // parallel takes over, serial frozen, T cleared
    set_pins(9'd200, 2'b01); set_pl(1'b0);     expect_now("R2 par clears T");
    send_bit(~e_sr[12]); send_bit(1'b1);       expect_now("R10 no shift");
    set_pl(1'b1);
    send_word({3'b011, 2'b01, 9'd126});
    set_sl(1'b1);                              expect_now("R4 R5 second word");
    set_sl(1'b0);                              expect_now("R6 second latch");

    wait_cyc(4);
    cmp("R5", "queue empty", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule